// File: doc/BRIEF.md
# Configurable Logic Cell

This block is one programmable element meant to be tiled across a reconfigurable logic fabric. Data passes through three stages in a fixed order. The first is a look-up table with K inputs. Its truth table is held in configuration storage. The second is a one-bit full adder with carry in and carry out, so that neighbouring cells can form a ripple carry chain. The third is a D flip-flop. Three configuration bits choose which stages are in use and which are bypassed. Seven of the eight combinations are the useful modes: table only, adder only, register only, table then register, adder then register, table then adder, and all three stages.

The configuration word loads over a serial chain, one bit per clock while `cfg_en` is high. The bit that falls off the far end appears on `cfg_dout`, so the chains of several cells can be joined in series. When a stage is bypassed, its input passes straight through to the next stage. Reset clears only the flip-flop.

The configuration word is `CFG_W = 2**K + 3` bits long. After a full load, bits [CFG_W-1:3] hold the truth table, bit 2 enables the table, bit 1 enables the adder and bit 0 enables the register. The first bit shifted in ends up in the top position.

Top module: `lc_logic_cell`

## Requirements
- R1: On each rising clock edge with `cfg_en` high, the configuration word shifts up by one position and `cfg_din` enters bit 0. After CFG_W such edges, the first bit sent sits at bit CFG_W-1, which is truth-table entry 2**K-1.
- R2: `cfg_dout` always shows the top bit of the configuration word. This is the bit that entered CFG_W shifts earlier.
- R3: While `cfg_en` is low, the configuration word keeps its value. The value is also kept through any number of reset cycles.
- R4: With the table enabled (bit 2 = 1), the table result is truth-table entry number `lut_in`. `lut_in[0]` is the least significant bit of the index. For example, entries 3, 7, 11 and 15 set (0x8888) give the AND of inputs 0 and 1.
- R5: With the table bypassed (bit 2 = 0), `lut_in[0]` is used in place of the table result.
- R6: With the adder enabled (bit 1 = 1), the stage result is the sum of the first operand, `op_b` and `carry_in`. `carry_out` is the majority of those three bits.
- R7: With the adder bypassed (bit 1 = 0), the first operand passes on unchanged and `carry_out` is 0.
- R8: With the register enabled (bit 0 = 1), `cell_out` is the stage result sampled at the previous rising edge. With the register bypassed, `cell_out` follows the stage result combinationally. The flip-flop captures on every edge where reset is low, including edges during a configuration load.
- R9: A rising edge with `rst` high clears the flip-flop, so a registered cell reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset of the flip-flop only |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_din | input | 1 | Serial configuration data in |
| cfg_dout | output | 1 | Serial configuration data out, for chaining |
| lut_in | input | K | Table index inputs; bit 0 is the least significant |
| op_b | input | 1 | Second operand of the adder |
| carry_in | input | 1 | Carry from the previous cell |
| carry_out | output | 1 | Carry to the next cell; 0 when the adder is bypassed |
| cell_out | output | 1 | Cell data output |

## Verification
The bench runs all eight combinations of stage-enable bits and applies all 64 combinations of the table index, second operand and carry in under each one. Each cycle is compared with a behavioural model, which catches a reversed index bit order (wrong table entries), a wrong bypass source, or a carry left active when the adder is bypassed. The register corner cases are the one-cycle latency and the clear on reset. A cell that responded combinationally, or that skipped the clear, would show the new value one cycle early or keep a stale 1. The bench also checks that reset does not touch the configuration, and it checks the serial order on `cfg_dout`. A chain that shifted the wrong way, or that reset its contents, would change the loaded function.

// File: rtl/lc_pkg.sv
package lc_pkg;

  localparam int unsigned LC_K_DEFAULT = 4;

  // Control bits at the bottom of the configuration word
  localparam int unsigned CTL_REG = 0;
  localparam int unsigned CTL_ADD = 1;
  localparam int unsigned CTL_LUT = 2;
  localparam int unsigned CTL_W   = 3;

  typedef struct packed {
    logic lut_en;
    logic add_en;
    logic reg_en;
  } lc_ctl_t;

  function automatic int unsigned lc_cfg_width(input int unsigned k);
    return (1 << k) + CTL_W;
  endfunction

endpackage

// File: rtl/lc_cfg_chain.sv
module lc_cfg_chain #(
  parameter int unsigned W = 19
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] word,
  output logic         dout
);

  logic [W-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (shift_en) begin
      chain_q <= {chain_q[W-2:0], din};
    end
  end

  assign word = chain_q;
  assign dout = chain_q[W-1];

  // R1: a shift moves the serial bit into the bottom position
  p_shift_in_r1: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> chain_q[0] == $past(din));

  // R3: contents held while shifting is off
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(chain_q));

endmodule

// File: rtl/lc_lut.sv
module lc_lut #(
  parameter int unsigned K = 4,
  localparam int unsigned N = 1 << K
) (
  input  logic [N-1:0] table_bits,
  input  logic [K-1:0] sel,
  output logic         f
);

  // Binary mux tree; level l reduces using index bit l-1
  for (genvar l = 0; l <= K; l++) begin : g_lvl
    logic [(N >> l)-1:0] v;
    if (l == 0) begin : g_leaf
      assign v = table_bits;
    end else begin : g_node
      for (genvar i = 0; i < (N >> l); i++) begin : g_mux
        assign v[i] = sel[l-1] ? g_lvl[l-1].v[2*i+1] : g_lvl[l-1].v[2*i];
      end
    end
  end

  assign f = g_lvl[K].v[0];

endmodule

// File: rtl/lc_arith.sv
module lc_arith (
  input  logic en,
  input  logic a,
  input  logic b,
  input  logic cin,
  output logic y,
  output logic cout
);

  logic prop, gen;

  always_comb begin
    prop = a ^ b;
    gen  = a & b;
    if (en) begin
      y    = prop ^ cin;
      cout = gen | (prop & cin);
    end else begin
      y    = a;
      cout = 1'b0;
    end
  end

endmodule

// File: rtl/lc_ff.sv
module lc_ff (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d;
  end

  // R8: the flip-flop presents the captured bit one edge later
  p_capture_one_r8: assert property (@(posedge clk) disable iff (rst)
    d |=> q);
  p_capture_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !d |=> !q);

  // R9: reset edge leaves the flip-flop cleared
  p_rst_clear_r9: assert property (@(posedge clk)
    rst |=> !q);

endmodule

// File: rtl/lc_logic_cell.sv
module lc_logic_cell
  import lc_pkg::*;
#(
  parameter int unsigned K = LC_K_DEFAULT
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_en,
  input  logic         cfg_din,
  output logic         cfg_dout,
  input  logic [K-1:0] lut_in,
  input  logic         op_b,
  input  logic         carry_in,
  output logic         carry_out,
  output logic         cell_out
);

  localparam int unsigned TT_N  = 1 << K;
  localparam int unsigned CFG_W = lc_cfg_width(K);

  logic [CFG_W-1:0] cfg_word;
  lc_ctl_t          ctl;
  logic [TT_N-1:0]  tt;
  logic             lut_f, opnd_a, stage_y, ff_q;

  lc_cfg_chain #(.W(CFG_W)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .shift_en (cfg_en),
    .din      (cfg_din),
    .word     (cfg_word),
    .dout     (cfg_dout)
  );

  assign tt         = cfg_word[CFG_W-1:CTL_W];
  assign ctl.lut_en = cfg_word[CTL_LUT];
  assign ctl.add_en = cfg_word[CTL_ADD];
  assign ctl.reg_en = cfg_word[CTL_REG];

  lc_lut #(.K(K)) u_lut (
    .table_bits (tt),
    .sel        (lut_in),
    .f          (lut_f)
  );

  // Stage 1 bypass
  assign opnd_a = ctl.lut_en ? lut_f : lut_in[0];

  // Stage 2 with its own bypass inside
  lc_arith u_add (
    .en   (ctl.add_en),
    .a    (opnd_a),
    .b    (op_b),
    .cin  (carry_in),
    .y    (stage_y),
    .cout (carry_out)
  );

  // Stage 3
  lc_ff u_ff (
    .clk (clk),
    .rst (rst),
    .d   (stage_y),
    .q   (ff_q)
  );

  assign cell_out = ctl.reg_en ? ff_q : stage_y;

endmodule

// File: tb/test_lc_logic_cell.sv
`timescale 1ns/1ps
module test_lc_logic_cell;

  localparam int K     = 4;
  localparam int CFG_W = (1 << K) + 3;

  logic clk = 1'b0;
  logic rst, cfg_en, cfg_din, op_b, carry_in;
  logic [K-1:0] lut_in;
  logic cfg_dout, carry_out, cell_out;

  int checks = 0;
  int failures = 0;
  bit chk_on = 0;

  always #10 clk = ~clk;

  lc_logic_cell #(.K(K)) i_lc_logic_cell (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .cfg_dout(cfg_dout), .lut_in(lut_in), .op_b(op_b),
    .carry_in(carry_in), .carry_out(carry_out), .cell_out(cell_out)
  );

  // Behavioural reference
  logic [CFG_W-1:0] mcfg;
  logic             mq;

  function automatic logic [1:0] mdl(input logic [CFG_W-1:0] c,
                                     input logic [K-1:0] li,
                                     input logic b, input logic ci);
    logic [15:0] t;
    logic a;
    int idx;
    int n;
    t = c[CFG_W-1:3];
    idx = int'(li);
    a = c[2] ? t[idx] : li[0];
    if (c[1]) begin
      n = int'(a) + int'(b) + int'(ci);
      return {n[0], n >= 2};
    end
    return {a, 1'b0};
  endfunction

  always @(posedge clk) begin
    logic [1:0] r;
    r = mdl(mcfg, lut_in, op_b, carry_in);
    mq = rst ? 1'b0 : r[1];
    if (cfg_en) mcfg = {mcfg[CFG_W-2:0], cfg_din};
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, 2 ns before each rising edge
  initial forever begin
    @(posedge clk);
    #18;
    if (chk_on) begin
      logic [1:0] r;
      string t;
      r = mdl(mcfg, lut_in, op_b, carry_in);
      t = mcfg[0] ? "R8" : mcfg[1] ? "R6" : mcfg[2] ? "R4" : "R5";
      check({t, " cell_out"}, cell_out, mcfg[0] ? mq : r[1]);
      check(mcfg[1] ? "R6 carry" : "R7 carry", carry_out, r[0]);
      check("R2 cfg_dout", cfg_dout, mcfg[CFG_W-1]);
    end
  end

  task automatic drive(input logic [K-1:0] li, input logic b, input logic ci);
    @(negedge clk);
    lut_in = li; op_b = b; carry_in = ci;
  endtask

  task automatic load(input logic [15:0] tt, input logic l, input logic a,
                      input logic r);
    logic [CFG_W-1:0] w;
    w = {tt, l, a, r};
    for (int i = CFG_W - 1; i >= 0; i--) begin
      @(negedge clk);
      cfg_en = 1'b1;
      cfg_din = w[i];
    end
    @(negedge clk);
    cfg_en = 1'b0;
    cfg_din = 1'b0;
  endtask

  initial begin
    rst = 1'b1; cfg_en = 1'b0; cfg_din = 1'b0;
    lut_in = '0; op_b = 1'b0; carry_in = 1'b0;
    repeat (3) @(posedge clk);
    // R1: AND of inputs 0 and 1, table only
    load(16'h8888, 1'b1, 1'b0, 1'b0);
    @(negedge clk); rst = 1'b0;
    chk_on = 1;
    drive(4'b0011, 1'b0, 1'b0); #5 check("R1 R4 and 11", cell_out, 1'b1);
    drive(4'b0001, 1'b0, 1'b0); #5 check("R4 and 01", cell_out, 1'b0);
    drive(4'b1110, 1'b0, 1'b0); #5 check("R4 and 10", cell_out, 1'b0);
    drive(4'b1011, 1'b1, 1'b1); #5 check("R4 and 11 hi", cell_out, 1'b1);
    check("R7 carry idle", carry_out, 1'b0);
    check("R2 top bit", cfg_dout, 1'b1);
    // R3: reset does not disturb the table
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    drive(4'b0111, 1'b0, 1'b0); #5 check("R3 config kept", cell_out, 1'b1);

    // All stage-enable combinations, all input patterns
    for (int m = 0; m < 8; m++) begin
      logic [2:0] md;
      logic [15:0] tt;
      md = 3'(7 - m);
      tt = 16'h6996 ^ (16'(m) * 16'h1357);
      load(tt, md[2], md[1], md[0]);
      for (int v = 0; v < 64; v++) begin
        logic [5:0] vv;
        vv = 6'(v);
        drive(vv[3:0], vv[4], vv[5]);
      end
    end

    // R6: adder only
    load(16'h0000, 1'b0, 1'b1, 1'b0);
    drive(4'b0001, 1'b1, 1'b1); #5
    check("R6 sum 111", cell_out, 1'b1);
    check("R6 carry 111", carry_out, 1'b1);
    drive(4'b0000, 1'b1, 1'b0); #5
    check("R6 sum 010", cell_out, 1'b1);
    check("R6 carry 010", carry_out, 1'b0);

    // R5: everything bypassed, table all ones ignored
    load(16'hFFFF, 1'b0, 1'b0, 1'b0);
    drive(4'b1110, 1'b1, 1'b1); #5 check("R5 bypass 0", cell_out, 1'b0);
    check("R7 carry off", carry_out, 1'b0);

    // R8: one-cycle latency, table copies input 0
    load(16'hAAAA, 1'b1, 1'b0, 1'b1);
    drive(4'b0000, 1'b0, 1'b0);
    drive(4'b0001, 1'b0, 1'b0); #5 check("R8 before edge", cell_out, 1'b0);
    @(posedge clk); #5 check("R8 after edge", cell_out, 1'b1);
    // R9: reset clears the registered output
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #5 check("R9 cleared", cell_out, 1'b0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #5 check("R9 resumes", cell_out, 1'b1);

    repeat (2) @(posedge clk);
    chk_on = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(64'd20 * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule